// File: doc/BRIEF.md
# Secure Doorbell Mailbox

This block is a register-mapped doorbell unit through which two processors, a host and a peer, signal each other. It holds one 32-bit status word for each direction. Channel 0 carries peer-to-host doorbells and channel 1 carries host-to-peer doorbells. A sender rings slot `n` by writing a one to bit `n` of the channel's set register. The receiver sees every pending slot in one status read, acknowledges by writing ones to the channel's clear register, and is woken by a level interrupt that stays high while any status bit of its channel is set.

Each processor reaches the registers through its own simple 32-bit request port, which carries a secure attribute. All doorbell registers are secure. Bit 31 of each status word is not a doorbell slot, which leaves 31 slots. Hardware sets bit 31 when a non-secure master touches that channel, and it stays set until a secure clear removes it. Because the two ports are independent, one port can set a bit in the same cycle that the other clears it. The set always wins.

Top module: `doorbell_mbox`

## Requirements
- R1: While reset is low and after it is released, both status words are zero, both `irq_o` bits are low and every `rdata_o` is zero.
- R2: A secure write to a set register (channel 0 at 0x208, channel 1 at 0x308) raises each status bit 30..0 whose data bit is 1. Data bits that are 0 have no effect, and data bit 31 is ignored.
- R3: A secure write to a clear register (channel 0 at 0x210, channel 1 at 0x310) lowers each status bit 31..0 whose data bit is 1. Data bits that are 0 have no effect.
- R4: A secure read of a status register (channel 0 at 0x200, channel 1 at 0x300) returns the full 32-bit status word on that port's `rdata_o` in the cycle after the request. The value returned is the status as it stood before any write made in the same cycle.
- R5: A read of a set or clear offset, a read of an unmapped offset and any write request each return zero on `rdata_o` in the next cycle. A write to an unmapped offset changes no status.
- R6: A non-secure request to any of the six channel registers changes no doorbell bit and reads zero. It sets bit 31 of that channel's status in the next cycle.
- R7: When a set and a clear of the same bit reach a channel in the same cycle, the bit ends up set. The bit can be set by a secure set write or by a non-secure access raising bit 31.
- R8: `irq_o[c]` is registered and active high: in each cycle it equals the OR of channel `c`'s status bits in the previous cycle.
- R9: An access to one channel never changes the other channel's status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_PORTS | Per-port request strobe, one cycle per access |
| we_i | input | NUM_PORTS | Per-port write enable (1 = write, 0 = read) |
| secure_i | input | NUM_PORTS | Per-port secure attribute of the access |
| addr_i | input | NUM_PORTS x ADDR_W | Per-port byte address |
| wdata_i | input | NUM_PORTS x DATA_W | Per-port write data |
| rdata_o | output | NUM_PORTS x DATA_W | Per-port read data, registered, valid the cycle after a read |
| irq_o | output | 2 | Level interrupt per channel: bit 0 toward host, bit 1 toward peer |

## Verification
There are two cases where a set and a clear can act on the same status bit in one cycle. In the first, one port writes the set register while the other port writes the clear register of the same channel with overlapping bits. In the second, one port makes a non-secure access while the other port securely clears bit 31 of the same channel. Directed cycles drive both cases, and so does the random phase, where both ports pick addresses from the same small pool. The result is judged by a later status read, compared with a bench model that applies clears first and then sets.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned NUM_CH  = 2;   // 0: peer-to-host, 1: host-to-peer
  localparam int unsigned OFS_SET = 'h08;
  localparam int unsigned OFS_CLR = 'h10;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter logic [NUM_CH-1:0][ADDR_W-1:0] BASES = '0
) (
  input  logic                           req_i,
  input  logic                           we_i,
  input  logic                           secure_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [NUM_CH-1:0][DATA_W-1:0]  set_o,
  output logic [NUM_CH-1:0][DATA_W-1:0]  clr_o,
  output logic [NUM_CH-1:0]              ns_o,
  output logic [NUM_CH-1:0]              rd_o
);
  localparam logic [ADDR_W-1:0] SET_OFS = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] CLR_OFS = ADDR_W'(OFS_CLR);

  logic sec_wr, sec_rd, ns_req;
  assign sec_wr = req_i & we_i & secure_i;
  assign sec_rd = req_i & ~we_i & secure_i;
  assign ns_req = req_i & ~secure_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit_stat, hit_set, hit_clr;
    assign hit_stat = (addr_i == BASES[c]);
    assign hit_set  = (addr_i == BASES[c] + SET_OFS);
    assign hit_clr  = (addr_i == BASES[c] + CLR_OFS);
    // top bit is not a slot: a set write never reaches it
    assign set_o[c] = (sec_wr & hit_set) ? {1'b0, wdata_i[DATA_W-2:0]} : '0;
    assign clr_o[c] = (sec_wr & hit_clr) ? wdata_i : '0;
    assign ns_o[c]  = ns_req & (hit_stat | hit_set | hit_clr);
    assign rd_o[c]  = sec_rd & hit_stat;
  end
endmodule

// File: rtl/mbox_channel.sv
module mbox_channel #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_PORTS = 2
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]  set_i,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]  clr_i,
  input  logic [NUM_PORTS-1:0]              ns_i,
  output logic [DATA_W-1:0]                 set_all_o,
  output logic [DATA_W-1:0]                 clr_all_o,
  output logic [DATA_W-1:0]                 stat_o,
  output logic                              irq_o
);
  logic [DATA_W-1:0] stat_q, stat_d;
  logic              irq_q;

  always_comb begin
    set_all_o = '0;
    clr_all_o = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      set_all_o = set_all_o | set_i[p];
      clr_all_o = clr_all_o | clr_i[p];
    end
    set_all_o[DATA_W-1] = set_all_o[DATA_W-1] | (|ns_i);
    // clear first, then set: set wins on collision
    stat_d = (stat_q & ~clr_all_o) | set_all_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= |stat_q;
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/mbox_rdata.sv
module mbox_rdata
  import mbox_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_CH-1:0]              rd_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  stat_i,
  output logic [DATA_W-1:0]              rdata_o
);
  logic [DATA_W-1:0] rd_d, rd_q;

  always_comb begin
    rd_d = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_i[c]) rd_d = rd_d | stat_i[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= rd_d;
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/doorbell_mbox.sv
module doorbell_mbox
  import mbox_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter logic [ADDR_W-1:0] RX_BASE = 'h200,
  parameter logic [ADDR_W-1:0] TX_BASE = 'h300
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_PORTS-1:0]              req_i,
  input  logic [NUM_PORTS-1:0]              we_i,
  input  logic [NUM_PORTS-1:0]              secure_i,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  addr_i,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]  wdata_i,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]  rdata_o,
  output logic [NUM_CH-1:0]                 irq_o
);
  localparam logic [NUM_CH-1:0][ADDR_W-1:0] BASES = {TX_BASE, RX_BASE};

  logic [NUM_PORTS-1:0][NUM_CH-1:0][DATA_W-1:0] dec_set, dec_clr;
  logic [NUM_PORTS-1:0][NUM_CH-1:0]             dec_ns, dec_rd;
  logic [NUM_CH-1:0][NUM_PORTS-1:0][DATA_W-1:0] ch_set, ch_clr;
  logic [NUM_CH-1:0][NUM_PORTS-1:0]             ch_ns;
  logic [NUM_CH-1:0][DATA_W-1:0]                stat_w, set_all_w, clr_all_w;
  logic [NUM_CH-1:0]                            ns_any_w;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    mbox_decode #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .BASES  (BASES)
    ) i_decode (
      .req_i    (req_i[p]),
      .we_i     (we_i[p]),
      .secure_i (secure_i[p]),
      .addr_i   (addr_i[p]),
      .wdata_i  (wdata_i[p]),
      .set_o    (dec_set[p]),
      .clr_o    (dec_clr[p]),
      .ns_o     (dec_ns[p]),
      .rd_o     (dec_rd[p])
    );

    mbox_rdata #(
      .DATA_W (DATA_W)
    ) i_rdata (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rd_i    (dec_rd[p]),
      .stat_i  (stat_w),
      .rdata_o (rdata_o[p])
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_xpose
      assign ch_set[c][p] = dec_set[p][c];
      assign ch_clr[c][p] = dec_clr[p][c];
      assign ch_ns[c][p]  = dec_ns[p][c];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign ns_any_w[c] = |ch_ns[c];

    mbox_channel #(
      .DATA_W    (DATA_W),
      .NUM_PORTS (NUM_PORTS)
    ) i_channel (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (ch_set[c]),
      .clr_i     (ch_clr[c]),
      .ns_i      (ch_ns[c]),
      .set_all_o (set_all_w[c]),
      .clr_all_o (clr_all_w[c]),
      .stat_o    (stat_w[c]),
      .irq_o     (irq_o[c])
    );
  end
endmodule

// File: rtl/mbox_chk.sv
module mbox_chk
  import mbox_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_PORTS-1:0]              req_i,
  input  logic [NUM_PORTS-1:0]              we_i,
  input  logic [NUM_PORTS-1:0]              secure_i,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]  rdata_o,
  input  logic [NUM_CH-1:0]                 irq_o,
  input  logic [NUM_CH-1:0][DATA_W-1:0]     stat_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]     set_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]     clr_i,
  input  logic [NUM_CH-1:0]                 ns_i
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !past_ok |-> (irq_o == '0 && rdata_o == '0)); // R1

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i[c] != '0) |=> ((stat_i[c] & $past(set_i[c])) == $past(set_i[c]))); // R7
    AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((clr_i[c] & ~set_i[c]) != '0) |=> ((stat_i[c] & $past(clr_i[c] & ~set_i[c])) == '0)); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i[c] == '0 && clr_i[c] == '0) |=> $stable(stat_i[c])); // R9
    AST_NS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ns_i[c] |=> stat_i[c][DATA_W-1]); // R6
    AST_IRQ_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok |-> (irq_o[c] == $past(|stat_i[c]))); // R8
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    AST_NS_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i[p] && !secure_i[p]) |=> (rdata_o[p] == '0)); // R6
    AST_WRITE_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i[p] && we_i[p]) |=> (rdata_o[p] == '0)); // R5
  end
endmodule

bind doorbell_mbox mbox_chk #(
  .NUM_PORTS (NUM_PORTS),
  .DATA_W    (DATA_W)
) i_mbox_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .secure_i (secure_i),
  .rdata_o  (rdata_o),
  .irq_o    (irq_o),
  .stat_i   (stat_w),
  .set_i    (set_all_w),
  .clr_i    (clr_all_w),
  .ns_i     (ns_any_w)
);

// File: tb/test_doorbell_mbox.sv
`timescale 1ns/1ps
module test_doorbell_mbox;
  localparam int NP = 2;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam real HALF = 2.5;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [NP-1:0]          req = '0, we = '0, sec = '0;
  logic [NP-1:0][AW-1:0]  addr = '0;
  logic [NP-1:0][DW-1:0]  wdata = '0;
  logic [NP-1:0][DW-1:0]  rdata;
  logic [1:0]             irq;

  int total = 0, bad = 0;
  bit done = 0;
  logic [DW-1:0] m_stat [2];

  always #(HALF) clk = ~clk;

  doorbell_mbox i_doorbell_mbox (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .secure_i(sec),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ch_of(input logic [AW-1:0] a);
    if (a[11:8] == 4'h2) return 0;
    if (a[11:8] == 4'h3) return 1;
    return -1;
  endfunction

  // 0 status, 1 set, 2 clear, 3 unmapped
  function automatic int kind_of(input logic [AW-1:0] a);
    if (ch_of(a) < 0) return 3;
    case (a[7:0])
      8'h00: return 0;
      8'h08: return 1;
      8'h10: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [AW-1:0] pick_addr(input int unsigned r);
    case (r % 9)
      0: return 12'h200; 1: return 12'h208; 2: return 12'h210;
      3: return 12'h300; 4: return 12'h308; 5: return 12'h310;
      6: return 12'h204; 7: return 12'h000; default: return 12'h318;
    endcase
  endfunction

  // one bus cycle on both ports; called at a falling edge
  task automatic step(input logic [NP-1:0] rq, input logic [NP-1:0] w, input logic [NP-1:0] s,
                      input logic [NP-1:0][AW-1:0] a, input logic [NP-1:0][DW-1:0] d);
    logic [DW-1:0] exp_rd [NP];
    string         rtag [NP];
    logic [DW-1:0] setm [2], clrm [2];
    logic [1:0]    exp_irq;
    req = rq; we = w; sec = s; addr = a; wdata = d;
    for (int c = 0; c < 2; c++) begin setm[c] = '0; clrm[c] = '0; end
    for (int p = 0; p < NP; p++) begin
      int c = ch_of(a[p]);
      int k = kind_of(a[p]);
      exp_rd[p] = '0;
      rtag[p]   = "R5";
      if (rq[p] && !s[p] && k != 3) begin
        rtag[p] = "R6";
        setm[c][31] = 1'b1;
      end else if (rq[p] && s[p] && !w[p] && k == 0) begin
        rtag[p] = "R4";
        exp_rd[p] = m_stat[c];
      end else if (rq[p] && s[p] && w[p] && k == 1) begin
        setm[c] = setm[c] | {1'b0, d[p][30:0]};
      end else if (rq[p] && s[p] && w[p] && k == 2) begin
        clrm[c] = clrm[c] | d[p];
      end
    end
    exp_irq = {|m_stat[1], |m_stat[0]};
    @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < 2; c++) m_stat[c] = (m_stat[c] & ~clrm[c]) | setm[c];
    for (int p = 0; p < NP; p++) chk(rtag[p], rdata[p], exp_rd[p]);
    chk("R8", {30'd0, irq}, {30'd0, exp_irq});
    req = '0;
  endtask

  task automatic idle();
    step('0, '0, '0, '0, '0);
  endtask

  task automatic wr1(input int p, input logic s, input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [NP-1:0][AW-1:0] aa = '0;
    logic [NP-1:0][DW-1:0] dd = '0;
    aa[p] = a; dd[p] = d;
    step(NP'(1) << p, NP'(1) << p, s ? (NP'(1) << p) : '0, aa, dd);
  endtask

  task automatic rd_stat(input string tag, input int ch, input logic [DW-1:0] exp);
    logic [NP-1:0][AW-1:0] aa = '0;
    aa[0] = (ch == 0) ? 12'h200 : 12'h300;
    step(2'b01, 2'b00, 2'b01, aa, '0);
    chk(tag, rdata[0], exp);
  endtask

  initial begin
    #(HALF * 2 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0][AW-1:0] aa;
    logic [NP-1:0][DW-1:0] dd;
    void'($urandom(32'h5eed_1234));
    m_stat[0] = '0; m_stat[1] = '0;
    repeat (3) @(negedge clk);
    // R1: outputs idle in reset
    chk("R1", rdata[0] | rdata[1], '0);
    chk("R1", {30'd0, irq}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_stat("R1", 0, '0);
    rd_stat("R1", 1, '0);

    // R2: set, bit 31 of data ignored
    wr1(0, 1'b1, 12'h208, 32'hFFFF_FFFF);
    rd_stat("R2", 0, 32'h7FFF_FFFF);
    rd_stat("R9", 1, 32'h0);
    wr1(1, 1'b1, 12'h208, 32'h0);
    rd_stat("R2", 0, 32'h7FFF_FFFF);
    chk("R8", {30'd0, irq}, 32'd1);

    // R3: clear, zeros do nothing
    wr1(1, 1'b1, 12'h210, 32'h0000_00F0);
    rd_stat("R3", 0, 32'h7FFF_FF0F);
    wr1(0, 1'b1, 12'h210, 32'h0);
    rd_stat("R3", 0, 32'h7FFF_FF0F);

    // R6: non-secure write ignored, flags bit 31
    wr1(1, 1'b0, 12'h308, 32'h0000_00FF);
    rd_stat("R6", 1, 32'h8000_0000);
    wr1(0, 1'b0, 12'h200, 32'h0);
    rd_stat("R6", 0, 32'hFFFF_FF0F);

    // R5: unmapped write, set/clear reads
    wr1(0, 1'b1, 12'h204, 32'hFFFF_FFFF);
    wr1(0, 1'b1, 12'h318, 32'hFFFF_FFFF);
    rd_stat("R5", 1, 32'h8000_0000);
    aa[0] = 12'h208; aa[1] = 12'h310;
    step(2'b11, 2'b00, 2'b11, aa, '0);
    chk("R5", rdata[0] | rdata[1], '0);

    // R7: set vs clear from two ports, same bit
    aa[0] = 12'h308; dd[0] = 32'h0000_0008;
    aa[1] = 12'h310; dd[1] = 32'h8000_0008;
    step(2'b11, 2'b11, 2'b11, aa, dd);
    rd_stat("R7", 1, 32'h0000_0008);
    aa[0] = 12'h200; dd[0] = 32'h0;
    aa[1] = 12'h210; dd[1] = 32'hFFFF_FFFF;
    step(2'b11, 2'b11, 2'b10, aa, dd);
    rd_stat("R7", 0, 32'h8000_0000);

    // R8: interrupt drops one cycle after clear
    wr1(0, 1'b1, 12'h210, 32'hFFFF_FFFF);
    wr1(0, 1'b1, 12'h310, 32'hFFFF_FFFF);
    idle();
    chk("R8", {30'd0, irq}, '0);
    wr1(1, 1'b1, 12'h308, 32'h4000_0000);
    chk("R8", {30'd0, irq}, '0);
    idle();
    chk("R8", {30'd0, irq}, 32'd2);

    // random mix on both ports
    for (int i = 0; i < 4000; i++) begin
      logic [NP-1:0] rq, w, s;
      for (int p = 0; p < NP; p++) begin
        rq[p] = ($urandom % 4) != 0;
        w[p]  = $urandom % 2;
        s[p]  = ($urandom % 8) != 0;
        aa[p] = pick_addr($urandom);
        case ($urandom % 4)
          0: dd[p] = 32'h1 << ($urandom % 32);
          1: dd[p] = 32'hFFFF_FFFF;
          default: dd[p] = $urandom;
        endcase
      end
      step(rq, w, s, aa, dd);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule